// File: doc/BRIEF.md
# Interrupt Acknowledge Hold Controller

This block decides, at every instruction boundary, whether a pending maskable interrupt is taken. It sits between a priority resolver and the instruction sequencer of a CPU. The sequencer reports each retiring instruction with a strobe and a decoded class tag. The resolver supplies a pending flag and the vector of the winning request. The global interrupt-enable flag is an input.

A request is taken only when all of these hold at the boundary:
- the enable flag is set;
- a request is pending;
- the retiring instruction belongs neither to the hold class nor to the software-break class.

Hold-class instructions are those that write the status word, enable or disable interrupts, return from an interrupt, perform a conditional skip, or write the interrupt flag, mask or priority registers. After such an instruction, the request waits at least one more instruction. A run of hold-class instructions keeps extending the wait. A software break is not hold-class, but it blocks acceptance because it clears the enable flag.

On acceptance the block pulses an acknowledge and an enable-clear strobe in the same cycle. It also captures the status word, the program counter and the vector. It then runs a sequencer with these states:
- **ST_IDLE**: waits for a boundary.
- **ST_SAVE_PSW**: writes the status word to the stack and stays until the stack reports ready.
- **ST_SAVE_PC**: writes the program counter to the stack and stays until ready.
- **ST_VECTOR**: loads the vector for one cycle, then returns to ST_IDLE.

The transitions are:
- **ACCEPT**: ST_IDLE to ST_SAVE_PSW.
- **PSW_DONE**: ST_SAVE_PSW to ST_SAVE_PC.
- **PC_DONE**: ST_SAVE_PC to ST_VECTOR.
- **LOAD_DONE**: ST_VECTOR to ST_IDLE.

Retire strobes that arrive while the sequencer is busy are ignored.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After a synchronous active-high reset, the sequencer is in ST_IDLE. busy_o, ack_o, ie_clr_o, stk_wr_o and pc_load_o are all 0.
- R2: When retire_i=1 in ST_IDLE with a class of normal (2'b00) or spare (2'b11), ie_i=1 and req_pending_i=1, then ack_o and ie_clr_o are 1 in that same cycle. From the next cycle busy_o=1.
- R3: A boundary whose class is hold (2'b01) never acknowledges. The request is taken at the next boundary with a normal class, so consecutive hold-class boundaries keep deferring it.
- R4: A boundary whose class is software break (2'b10) never acknowledges, even with ie_i=1 and a pending request.
- R5: With ie_i=0 at a boundary, no acknowledge is produced.
- R6: A request that is withdrawn (req_pending_i=0) at the boundary is not taken. No ack_o pulse appears.
- R7: After acceptance, the status word is written first (stk_wr_o=1, stk_sel_o=0). The program counter is written next (stk_sel_o=1). Each write holds, with stable data, until stk_ready_i=1. Then pc_load_o=1 for exactly one cycle, and the block is idle again.
- R8: While busy_o=1, retire_i is ignored: ack_o and ie_clr_o stay 0.
- R9: The stacked status word, stacked program counter and loaded vector are the values of psw_i, pc_i and req_vec_i in the acceptance cycle, zero-extended to the stack width. Later changes to these inputs have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | Instruction retire strobe |
| retire_cls_i | input | 2 | Class of the retiring instruction: 00 normal, 01 hold, 10 break, 11 spare (normal) |
| ie_i | input | 1 | Global interrupt-enable flag |
| req_pending_i | input | 1 | A maskable request is pending |
| req_vec_i | input | VEC_W | Vector of the pending request |
| psw_i | input | PSW_W | Current status word |
| pc_i | input | PC_W | Return program counter |
| stk_ready_i | input | 1 | Stack accepts the current write |
| ack_o | output | 1 | Acceptance pulse |
| ie_clr_o | output | 1 | Clear the global enable flag |
| busy_o | output | 1 | Sequencer not in ST_IDLE |
| stk_wr_o | output | 1 | Stack write request |
| stk_sel_o | output | 1 | 0: status word being stacked, 1: program counter |
| stk_data_o | output | STK_W | Stack write data |
| pc_load_o | output | 1 | Load the vector into the program counter |
| pc_load_vec_o | output | VEC_W | Vector to load |

## Verification
Two situations can fall in the same cycle: a new boundary with a pending request, and the save sequence of an earlier acceptance.

The bench provokes this by asserting retire_i with a normal class, ie_i=1 and a pending request during every busy cycle. It also inserts random stack-ready stalls and scrambles psw_i, pc_i and req_vec_i at the same time.

It then judges two things:
- ack_o stays 0 throughout the sequence.
- The stacked values and the loaded vector still match those captured at the original boundary.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

    typedef enum logic [1:0] {
        CLS_NORMAL = 2'b00,
        CLS_HOLD   = 2'b01,
        CLS_BREAK  = 2'b10,
        CLS_SPARE  = 2'b11
    } retire_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'b00,
        ST_SAVE_PSW = 2'b01,
        ST_SAVE_PC  = 2'b10,
        ST_VECTOR   = 2'b11
    } seq_state_e;

    localparam logic STK_SEL_PSW = 1'b0;
    localparam logic STK_SEL_PC  = 1'b1;

endpackage

// File: rtl/irq_accept_gate.sv
module irq_accept_gate
    import irq_accept_pkg::*;
(
    input  logic       idle_i,
    input  logic       retire_i,
    input  logic [1:0] retire_cls_i,
    input  logic       ie_i,
    input  logic       req_pending_i,
    output logic       accept_o
);

    logic cls_hold;
    logic cls_break;
    logic boundary_open;

    always_comb begin
        cls_hold      = (retire_cls_i == CLS_HOLD);
        cls_break     = (retire_cls_i == CLS_BREAK);
        // a boundary is only usable when the sequencer is free
        boundary_open = idle_i && retire_i;
        // hold class defers to the next boundary; break clears enable itself
        accept_o      = boundary_open && !cls_hold && !cls_break
                        && ie_i && req_pending_i;
    end

endmodule

// File: rtl/irq_save_seq.sv
module irq_save_seq
    import irq_accept_pkg::*;
#(
    parameter int PSW_W = 8,
    parameter int PC_W  = 20,
    parameter int VEC_W = 16,
    parameter int STK_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [PSW_W-1:0] psw_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic [VEC_W-1:0] vec_i,
    input  logic             stk_ready_i,
    output logic             idle_o,
    output logic             stk_wr_o,
    output logic             stk_sel_o,
    output logic [STK_W-1:0] stk_data_o,
    output logic             pc_load_o,
    output logic [VEC_W-1:0] pc_load_vec_o
);

    seq_state_e       state_q;
    seq_state_e       state_d;
    logic [PSW_W-1:0] psw_q;
    logic [PC_W-1:0]  pc_q;
    logic [VEC_W-1:0] vec_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // capture of the context at the accepting boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            psw_q <= '0;
            pc_q  <= '0;
            vec_q <= '0;
        end else if (start_i && (state_q == ST_IDLE)) begin
            psw_q <= psw_i;
            pc_q  <= pc_i;
            vec_q <= vec_i;
        end
    end

    // transitions: ACCEPT, PSW_DONE, PC_DONE, LOAD_DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i)     state_d = ST_SAVE_PSW;
            ST_SAVE_PSW: if (stk_ready_i) state_d = ST_SAVE_PC;
            ST_SAVE_PC:  if (stk_ready_i) state_d = ST_VECTOR;
            ST_VECTOR:                    state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        idle_o        = 1'b0;
        stk_wr_o      = 1'b0;
        stk_sel_o     = STK_SEL_PSW;
        stk_data_o    = '0;
        pc_load_o     = 1'b0;
        pc_load_vec_o = vec_q;
        unique case (state_q)
            ST_IDLE: begin
                idle_o = 1'b1;
            end
            ST_SAVE_PSW: begin
                stk_wr_o   = 1'b1;
                stk_sel_o  = STK_SEL_PSW;
                stk_data_o = STK_W'(psw_q);
            end
            ST_SAVE_PC: begin
                stk_wr_o   = 1'b1;
                stk_sel_o  = STK_SEL_PC;
                stk_data_o = STK_W'(pc_q);
            end
            ST_VECTOR: begin
                pc_load_o = 1'b1;
            end
            default: begin
                idle_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
    import irq_accept_pkg::*;
#(
    parameter int PSW_W = 8,
    parameter int PC_W  = 20,
    parameter int VEC_W = 16,
    parameter int STK_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             retire_i,
    input  logic [1:0]       retire_cls_i,
    input  logic             ie_i,
    input  logic             req_pending_i,
    input  logic [VEC_W-1:0] req_vec_i,
    input  logic [PSW_W-1:0] psw_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic             stk_ready_i,
    output logic             ack_o,
    output logic             ie_clr_o,
    output logic             busy_o,
    output logic             stk_wr_o,
    output logic             stk_sel_o,
    output logic [STK_W-1:0] stk_data_o,
    output logic             pc_load_o,
    output logic [VEC_W-1:0] pc_load_vec_o
);

    logic seq_idle;
    logic accept;

    irq_accept_gate u_gate (
        .idle_i        (seq_idle),
        .retire_i      (retire_i),
        .retire_cls_i  (retire_cls_i),
        .ie_i          (ie_i),
        .req_pending_i (req_pending_i),
        .accept_o      (accept)
    );

    irq_save_seq #(
        .PSW_W (PSW_W),
        .PC_W  (PC_W),
        .VEC_W (VEC_W),
        .STK_W (STK_W)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .start_i       (accept),
        .psw_i         (psw_i),
        .pc_i          (pc_i),
        .vec_i         (req_vec_i),
        .stk_ready_i   (stk_ready_i),
        .idle_o        (seq_idle),
        .stk_wr_o      (stk_wr_o),
        .stk_sel_o     (stk_sel_o),
        .stk_data_o    (stk_data_o),
        .pc_load_o     (pc_load_o),
        .pc_load_vec_o (pc_load_vec_o)
    );

    always_comb begin
        ack_o    = accept;
        ie_clr_o = accept;
        busy_o   = !seq_idle;
    end

endmodule

// File: rtl/irq_accept_ctrl_chk.sv
module irq_accept_ctrl_chk #(
    parameter int VEC_W = 16,
    parameter int STK_W = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             retire_i,
    input logic [1:0]       retire_cls_i,
    input logic             ie_i,
    input logic             req_pending_i,
    input logic             stk_ready_i,
    input logic             ack_o,
    input logic             busy_o,
    input logic             stk_wr_o,
    input logic             stk_sel_o,
    input logic [STK_W-1:0] stk_data_o,
    input logic             pc_load_o,
    input logic [VEC_W-1:0] pc_load_vec_o
);

    AST_ACK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> ie_i) else $error("ack without enable"); // R5

    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> (req_pending_i && retire_i)) else $error("ack without request"); // R6

    AST_HOLD_DEFERS: assert property (@(posedge clk) disable iff (rst)
        (retire_i && retire_cls_i == 2'b01) |-> !ack_o) else $error("ack at hold boundary"); // R3

    AST_BREAK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (retire_i && retire_cls_i == 2'b10) |-> !ack_o) else $error("ack at break boundary"); // R4

    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !ack_o) else $error("ack while busy"); // R8

    AST_ACK_THEN_PSW: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> (stk_wr_o && stk_sel_o == 1'b0)) else $error("psw not first"); // R7

    AST_STALL_STABLE: assert property (@(posedge clk) disable iff (rst)
        (stk_wr_o && !stk_ready_i) |=> (stk_wr_o && $stable(stk_data_o) && $stable(stk_sel_o)))
        else $error("stack write changed while stalled"); // R7

    AST_PC_THEN_LOAD: assert property (@(posedge clk) disable iff (rst)
        (stk_wr_o && stk_sel_o && stk_ready_i) |=> pc_load_o) else $error("no load after pc"); // R7

    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        pc_load_o |=> (!pc_load_o && !busy_o && $stable(pc_load_vec_o))) else $error("load too long"); // R7

endmodule

bind irq_accept_ctrl irq_accept_ctrl_chk #(
    .VEC_W (VEC_W),
    .STK_W (STK_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .retire_i      (retire_i),
    .retire_cls_i  (retire_cls_i),
    .ie_i          (ie_i),
    .req_pending_i (req_pending_i),
    .stk_ready_i   (stk_ready_i),
    .ack_o         (ack_o),
    .busy_o        (busy_o),
    .stk_wr_o      (stk_wr_o),
    .stk_sel_o     (stk_sel_o),
    .stk_data_o    (stk_data_o),
    .pc_load_o     (pc_load_o),
    .pc_load_vec_o (pc_load_vec_o)
);

// File: tb/irq_accept_ctrl_bench.sv
module irq_accept_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PSW_W = 8;
    localparam int PC_W  = 20;
    localparam int VEC_W = 16;
    localparam int STK_W = 20;
    localparam int WATCHDOG_CYCLES = 100000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             retire_i = 1'b0;
    logic [1:0]       retire_cls_i = 2'b00;
    logic             ie_i = 1'b0;
    logic             req_pending_i = 1'b0;
    logic [VEC_W-1:0] req_vec_i = '0;
    logic [PSW_W-1:0] psw_i = '0;
    logic [PC_W-1:0]  pc_i = '0;
    logic             stk_ready_i = 1'b0;
    logic             ack_o;
    logic             ie_clr_o;
    logic             busy_o;
    logic             stk_wr_o;
    logic             stk_sel_o;
    logic [STK_W-1:0] stk_data_o;
    logic             pc_load_o;
    logic [VEC_W-1:0] pc_load_vec_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    irq_accept_ctrl #(
        .PSW_W (PSW_W), .PC_W (PC_W), .VEC_W (VEC_W), .STK_W (STK_W)
    ) u_irq_accept_ctrl (
        .clk (clk), .rst (rst), .retire_i (retire_i), .retire_cls_i (retire_cls_i),
        .ie_i (ie_i), .req_pending_i (req_pending_i), .req_vec_i (req_vec_i),
        .psw_i (psw_i), .pc_i (pc_i), .stk_ready_i (stk_ready_i),
        .ack_o (ack_o), .ie_clr_o (ie_clr_o), .busy_o (busy_o),
        .stk_wr_o (stk_wr_o), .stk_sel_o (stk_sel_o), .stk_data_o (stk_data_o),
        .pc_load_o (pc_load_o), .pc_load_vec_o (pc_load_vec_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        check(act == exp, req, what, act, exp);
    endtask

    function automatic bit exp_accept(input bit ret, input logic [1:0] cls,
                                      input bit ie, input bit pend);
        return ret && (cls != 2'b01) && (cls != 2'b10) && ie && pend;
    endfunction

    function automatic string reason_tag(input bit ret, input logic [1:0] cls,
                                         input bit ie, input bit pend);
        if (ret && cls == 2'b01) return "R3";
        if (ret && cls == 2'b10) return "R4";
        if (!ie)                 return "R5";
        if (!pend)               return "R6";
        return "R2";
    endfunction

    // drives a boundary at a negedge and checks the same-cycle acknowledge
    task automatic boundary(input bit ret, input logic [1:0] cls, input bit ie,
                            input bit pend, output bit taken);
        string tag;
        retire_i      = ret;
        retire_cls_i  = cls;
        ie_i          = ie;
        req_pending_i = pend;
        req_vec_i     = VEC_W'($urandom);
        psw_i         = PSW_W'($urandom);
        pc_i          = PC_W'($urandom);
        #1;
        taken = exp_accept(ret, cls, ie, pend);
        tag = reason_tag(ret, cls, ie, pend);
        check_eq(tag, "ack_o", 32'(ack_o), 32'(taken));
        check_eq(tag, "ie_clr_o", 32'(ie_clr_o), 32'(taken));
    endtask

    // a busy cycle: offer a competing boundary, scramble the context inputs
    task automatic busy_noise();
        retire_i      = 1'b1;
        retire_cls_i  = 2'b00;
        ie_i          = 1'b1;
        req_pending_i = 1'b1;
        req_vec_i     = VEC_W'($urandom);
        psw_i         = PSW_W'($urandom);
        pc_i          = PC_W'($urandom);
        #1;
        check_eq("R8", "ack_o while busy", 32'(ack_o), 32'd0);
    endtask

    task automatic stack_step(input logic sel, input logic [STK_W-1:0] exp_data);
        int stalls;
        stalls = int'($urandom % 3);
        for (int s = 0; s <= stalls; s++) begin
            @(negedge clk);
            stk_ready_i = (s == stalls);
            busy_noise();
            check_eq("R7", "stk_wr_o", 32'(stk_wr_o), 32'd1);
            check_eq("R7", "stk_sel_o", 32'(stk_sel_o), 32'(sel));
            check_eq("R9", "stk_data_o", 32'(stk_data_o), 32'(exp_data));
            check_eq("R2", "busy_o", 32'(busy_o), 32'd1);
        end
    endtask

    // called after the accepting boundary, before its posedge
    task automatic run_sequence(input logic [PSW_W-1:0] psw, input logic [PC_W-1:0] pc,
                                input logic [VEC_W-1:0] vec);
        stack_step(1'b0, STK_W'(psw));
        stack_step(1'b1, STK_W'(pc));
        @(negedge clk);
        stk_ready_i = 1'b0;
        busy_noise();
        check_eq("R7", "pc_load_o", 32'(pc_load_o), 32'd1);
        check_eq("R7", "stk_wr_o in load", 32'(stk_wr_o), 32'd0);
        check_eq("R9", "pc_load_vec_o", 32'(pc_load_vec_o), 32'(vec));
        @(negedge clk);
        retire_i = 1'b0;
        #1;
        check_eq("R7", "pc_load_o after load", 32'(pc_load_o), 32'd0);
        check_eq("R7", "busy_o after load", 32'(busy_o), 32'd0);
    endtask

    task automatic step_boundary(input bit ret, input logic [1:0] cls, input bit ie,
                                 input bit pend);
        bit taken;
        logic [PSW_W-1:0] p;
        logic [PC_W-1:0]  c;
        logic [VEC_W-1:0] v;
        @(negedge clk);
        boundary(ret, cls, ie, pend, taken);
        p = psw_i;
        c = pc_i;
        v = req_vec_i;
        if (taken) run_sequence(p, c, v);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq("R1", "busy_o in reset", 32'(busy_o), 32'd0);
        check_eq("R1", "stk_wr_o in reset", 32'(stk_wr_o), 32'd0);
        check_eq("R1", "pc_load_o in reset", 32'(pc_load_o), 32'd0);
        rst = 1'b0;
        #1;
        check_eq("R1", "ack_o after reset", 32'(ack_o), 32'd0);
        check_eq("R1", "ie_clr_o after reset", 32'(ie_clr_o), 32'd0);

        // directed: plain accept
        step_boundary(1'b1, 2'b00, 1'b1, 1'b1);
        // directed: hold then normal takes it
        step_boundary(1'b1, 2'b01, 1'b1, 1'b1);
        step_boundary(1'b1, 2'b00, 1'b1, 1'b1);
        // directed: chain of hold boundaries keeps deferring
        step_boundary(1'b1, 2'b01, 1'b1, 1'b1);
        step_boundary(1'b1, 2'b01, 1'b1, 1'b1);
        step_boundary(1'b1, 2'b01, 1'b1, 1'b1);
        step_boundary(1'b1, 2'b11, 1'b1, 1'b1);
        // directed: break, disabled, withdrawn, no retire
        step_boundary(1'b1, 2'b10, 1'b1, 1'b1);
        step_boundary(1'b1, 2'b00, 1'b0, 1'b1);
        step_boundary(1'b1, 2'b00, 1'b1, 1'b0);
        step_boundary(1'b0, 2'b00, 1'b1, 1'b1);

        // random mix
        for (int i = 0; i < 400; i++) begin
            step_boundary(($urandom % 5) != 0, 2'($urandom % 4),
                          ($urandom % 4) != 0, ($urandom % 3) != 0);
        end

        // reset during a sequence returns to idle
        @(negedge clk);
        begin
            bit taken;
            boundary(1'b1, 2'b00, 1'b1, 1'b1, taken);
        end
        @(negedge clk);
        retire_i = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check_eq("R1", "busy_o after mid-sequence reset", 32'(busy_o), 32'd0);
        check_eq("R1", "stk_wr_o after mid-sequence reset", 32'(stk_wr_o), 32'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule